// File: doc/BRIEF.md
# SPI Serial Clock Divider with Linear and Power-of-Two Modes

This block produces the serial clock of an SPI master from the module clock. A half-period tick marks each serial clock edge, and the serial clock output toggles once for each tick. A configuration word selects one of two divider schemes. The linear scheme divides by an even integer, 2*(n+1). The exponential scheme divides by a power of two, 2^(n+1), and reaches the slow rates that the linear field cannot.

The transfer engine holds `busy_i` high for the length of a burst. While `busy_i` is low, the divider is parked: the counter is zero and the serial clock is low. Every burst therefore starts with the same phase. Software may write the configuration word at any time. A new value takes effect only when the divider is parked or at a half-period boundary, so the divider never emits a shortened half-period.

Top module: `spi_clk_div`

## Requirements
- R1: After reset, `tick_o` and `sclk_o` are low and the configuration word is zero (exponential mode, n=0), so a burst started without any write ticks on every cycle.
- R2: With configuration bit 12 set (linear mode), the half-period is n+1 module clocks, where n is the unsigned field in bits 7:0. The first tick comes in the (n+1)th cycle of `busy_i` high, and later ticks follow every n+1 cycles.
- R3: With configuration bit 12 clear (exponential mode), the half-period is 2^n module clocks, where n is the unsigned field in bits 11:8.
- R4: In linear mode with n=0, `tick_o` is high on every busy cycle and `sclk_o` toggles on every clock edge.
- R5: While `busy_i` is low, `tick_o` is low, `sclk_o` returns low on the next edge and the counter returns to zero.
- R6: A write while `busy_i` is high leaves the half-period in progress at its old length. The new divide ratio applies from the next tick onward.
- R7: In each mode, the field of the other mode has no effect on the tick spacing.
- R8: `sclk_o` changes on the edge that follows a tick and holds its value otherwise. It is low when the first tick of a burst appears.
- R9: The end points of both ranges are exact: linear n=255 gives 256 cycles per half-period, and exponential n=15 gives 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | LIN_W+EXP_W+1 | Configuration word: linear n in bits 7:0, exponential n in bits 11:8, bit 12 selects linear when set |
| busy_i | input | 1 | High while the transfer engine runs a burst |
| tick_o | output | 1 | Half-period tick, one module clock wide |
| sclk_o | output | 1 | Serial clock, toggled after each tick |

## Verification
The bench builds the block with the default widths: an 8-bit linear field and a 4-bit exponential field. These widths put both range end points in reach, 256 cycles in linear mode and 32768 cycles in exponential mode, and the bench measures both exactly within its run. It also times the spacing of ticks for a table of settings that includes conflicting values in the unused field. A directed case rewrites the divider in the middle of a burst to show that the old half-period completes before the new ratio applies.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
  typedef enum logic {
    DIV_EXP = 1'b0,
    DIV_LIN = 1'b1
  } div_mode_e;
endpackage

// File: rtl/spi_clk_div_cfg.sv
module spi_clk_div_cfg
  import spi_clk_div_pkg::*;
#(
  parameter int LIN_W  = 8,
  parameter int EXP_W  = 4,
  parameter int TERM_W = 15,
  localparam int CFG_W = LIN_W + EXP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              load_i,
  output logic [TERM_W-1:0] term_o
);
  localparam int SEL_BIT = LIN_W + EXP_W;

  logic [CFG_W-1:0]  shadow_q;
  logic [LIN_W-1:0]  lin_n;
  logic [EXP_W-1:0]  exp_n;
  div_mode_e         mode;
  logic [TERM_W-1:0] lin_term, exp_term, next_term, term_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= '0;
    else if (we_i) shadow_q <= wdata_i;
  end

  assign lin_n = shadow_q[LIN_W-1:0];
  assign exp_n = shadow_q[SEL_BIT-1:LIN_W];
  assign mode  = div_mode_e'(shadow_q[SEL_BIT]);

  // terminal count is half-period minus one
  assign lin_term = TERM_W'(lin_n);
  assign exp_term = (TERM_W'(1) << exp_n) - TERM_W'(1);
  assign next_term = (mode == DIV_LIN) ? lin_term : exp_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     term_q <= '0;
    else if (load_i) term_q <= next_term;
  end

  assign term_o = term_q;
endmodule

// File: rtl/spi_clk_div_cnt.sv
module spi_clk_div_cnt #(
  parameter int TERM_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [TERM_W-1:0] term_i,
  output logic              tick_o,
  output logic [TERM_W-1:0] cnt_o
);
  logic [TERM_W-1:0] cnt_q;

  assign tick_o = busy_i && (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!busy_i) cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + TERM_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/spi_clk_div_sclk.sv
module spi_clk_div_sclk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic tick_i,
  output logic sclk_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sclk_q <= 1'b0;
    else if (!busy_i) sclk_q <= 1'b0;
    else if (tick_i)  sclk_q <= ~sclk_q;
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W  = LIN_W + EXP_W + 1,
  localparam int EXP_MAX = (1 << EXP_W) - 1,
  localparam int TERM_W = (LIN_W > EXP_MAX) ? LIN_W : EXP_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             busy_i,
  output logic             tick_o,
  output logic             sclk_o
);
  logic [TERM_W-1:0] term_q;
  logic [TERM_W-1:0] cnt_q;
  logic              tick;
  logic              load;

  // reload only when parked or on a half-period boundary
  assign load = !busy_i || tick;

  spi_clk_div_cfg #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .TERM_W(TERM_W)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .load_i (load),
    .term_o (term_q)
  );

  spi_clk_div_cnt #(
    .TERM_W(TERM_W)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(busy_i),
    .term_i(term_q),
    .tick_o(tick),
    .cnt_o (cnt_q)
  );

  spi_clk_div_sclk u_sclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(busy_i),
    .tick_i(tick),
    .sclk_o(sclk_o)
  );

  assign tick_o = tick;
endmodule

// File: rtl/spi_clk_div_chk.sv
module spi_clk_div_chk #(
  parameter int TERM_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              tick_i,
  input logic              sclk_i,
  input logic [TERM_W-1:0] cnt_i,
  input logic [TERM_W-1:0] term_i
);
  p_idle_no_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !tick_i);

  p_idle_sclk_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !sclk_i);

  p_idle_cnt_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (cnt_i == '0));

  p_sclk_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && tick_i) |=> (sclk_i != $past(sclk_i)));

  p_sclk_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tick_i) |=> $stable(sclk_i));

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= term_i);

  p_term_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tick_i) |=> $stable(term_i));

  p_min_div_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && term_i == '0) |-> tick_i);
endmodule

bind spi_clk_div spi_clk_div_chk #(.TERM_W(TERM_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .busy_i(busy_i),
  .tick_i(tick_o),
  .sclk_i(sclk_o),
  .cnt_i (cnt_q),
  .term_i(term_q)
);

// File: tb/spi_clk_div_test.sv
`timescale 1ns/1ps
module spi_clk_div_test;
  localparam int CFG_W = 13;
  localparam int NV = 9;

  localparam logic [CFG_W-1:0] V_CFG [NV] = '{
    13'h1000, 13'h1003, 13'h10FF, 13'h0000, 13'h0100,
    13'h0500, 13'h0A00, 13'h1A07, 13'h0033
  };
  localparam int V_HALF [NV] = '{1, 4, 256, 1, 2, 32, 1024, 8, 1};
  localparam int V_TICKS [NV] = '{6, 4, 2, 4, 4, 3, 2, 3, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic busy = 1'b0;
  logic tick, sclk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_clk_div uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we),
    .cfg_wdata_i(cfg_wdata),
    .busy_i     (busy),
    .tick_o     (tick),
    .sclk_o     (sclk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [CFG_W-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_burst(input int half, input int nt, input string tag);
    int c = 0;
    int k = 0;
    int last = 0;
    busy = 1'b1;
    while (k < nt && c < half * nt + 8) begin
      #1;
      c++;
      if (tick) begin
        k++;
        check(c - last == half, {tag, " spacing"}, c - last, half);
        check(sclk == ((k - 1) & 1), {tag, " sclk R8"}, int'(sclk), (k - 1) & 1);
        last = c;
      end
      @(negedge clk);
    end
    check(k == nt, {tag, " tick count"}, k, nt);
    busy = 1'b0;
    #1;
    check(tick == 1'b0, {tag, " idle tick R5"}, int'(tick), 0);
    @(negedge clk);
    check(sclk == 1'b0, {tag, " idle sclk R5"}, int'(sclk), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] seen;
    // R1: reset state
    #1;
    check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    check(sclk == 1'b0, "R1 sclk in reset", int'(sclk), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    run_burst(1, 3, "R1 reset config");

    // table: R2 R3 R4 R7
    for (int i = 0; i < NV; i++) begin
      write_cfg(V_CFG[i]);
      run_burst(V_HALF[i], V_TICKS[i], $sformatf("R2/R3/R4/R7 vec%0d", i));
    end

    // R9: exponential end point
    write_cfg(13'h0F00);
    run_burst(32768, 1, "R9 exp n=15");

    // R6: rewrite mid burst, old half-period completes first
    write_cfg(13'h1003);
    seen = '0;
    busy = 1'b1;
    for (int c = 1; c <= 8; c++) begin
      #1;
      seen[c] = tick;
      if (c == 2) begin
        cfg_we = 1'b1;
        cfg_wdata = 13'h1001;
      end
      @(negedge clk);
      cfg_we = 1'b0;
    end
    busy = 1'b0;
    check(seen == 16'h0150, "R6 tick pattern", int'(seen), 16'h0150);
    @(negedge clk);
    // R7: idle write applies to the following burst
    run_burst(2, 3, "R7 after idle");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule